// File: doc/BRIEF.md
# Exhaustive Peripheral-Bus Address Decoder with Built-In Error Target

This block sits between the manager side of a peripheral-bus bridge (APB) and a set of peripherals. It compares the manager's address against a parameterised map of address regions, each with an inclusive base and limit. For each region it raises one select line, and it gates every select with the manager's transfer select. An address that falls in no region selects a built-in error target. This covers a reserved hole between regions and anything below or above the map. The error target completes the transfer and flags it as an error, so an unmapped address can never leave the manager waiting for a ready that nobody will drive.

A response multiplexer returns the ready, error and read data of whichever target is selected to the manager, and the built-in error target is one of its inputs. The bus has no valid/ready stream: back-pressure is the bus's own ready signal. The manager holds its select, enable and address steady while the returned ready is low, and a transfer ends on the first clock edge where ready is high during the enable phase. In the default configuration the map has three 4 KiB regions: region 0 at 0x4000_0000–0x4000_0FFF, region 1 at 0x4000_1000–0x4000_1FFF and region 2 at 0x4000_3000–0x4000_3FFF. 0x4000_2000–0x4000_2FFF is a reserved hole.

Top module: `apb_hole_decoder`

## Requirements
- R1: Bit i of `tgt_sel` is high exactly when `mgr_sel` is high and `mgr_addr` lies within region i inclusive of both its base and its limit (region 0, 1, 2 as listed above for the default map).
- R2: With `mgr_sel` low, every bit of `tgt_sel` is low, and `mgr_ready` and `mgr_err` are 0.
- R3: Whenever `mgr_sel` and `mgr_enable` are both high, exactly one target is selected: one bit of `tgt_sel`, or the built-in error target.
- R4: An access to an address in no region completes with `mgr_ready` and `mgr_err` both 1 in the same cycle. This holds for the reserved hole and for addresses below or above the map.
- R5: A no-hit access takes exactly one wait state. `mgr_ready` is 0 in the first enable-phase cycle and 1 in the second.
- R6: The error target's ready and error flags are registered and cleared by the asynchronous active-low reset `rst_n`. While in reset, `mgr_ready` and `mgr_err` read 0.
- R7: On a region hit, `mgr_ready`, `mgr_err` and `mgr_rdata` equal that region's `tgt_ready` bit, `tgt_err` bit and `tgt_rdata` slice. Slice i occupies bits [32*i+31:32*i].
- R8: On a no-hit completion, `mgr_rdata` is all zeros.
- R9: An enable-phase access never waits more than `MAX_WAIT` cycles for ready, provided the selected region's own ready arrives within that bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgr_sel | input | 1 | Manager transfer select |
| mgr_enable | input | 1 | Manager enable (access phase) |
| mgr_addr | input | ADDR_W | Manager address |
| mgr_ready | output | 1 | Ready returned to the manager |
| mgr_err | output | 1 | Error flag returned to the manager |
| mgr_rdata | output | DATA_W | Read data returned to the manager |
| tgt_sel | output | N_REG | One select per mapped region |
| tgt_ready | input | N_REG | Ready from each region's peripheral |
| tgt_err | input | N_REG | Error flag from each region's peripheral |
| tgt_rdata | input | N_REG*DATA_W | Read data from each peripheral, slice per region |

## Verification
Two of the block's functions can fall in the same cycle. The error target registers its completion, and the multiplexer passes a region's ready and error through combinationally. The error completion must not leak into a region's response, and a stale error flag must not appear on the next access. The bench provokes this by alternating hit and no-hit accesses back to back. It drives all peripheral ready and error inputs high while a no-hit is in its first wait cycle, and again after one completes. It judges each cycle against an address-range calculation of its own, so a hit must show the peripheral's value and a no-hit must show zero ready and then ready with error.

// File: rtl/apb_dec_pkg.sv
package apb_dec_pkg;
  localparam int ADDR_W_DFLT = 32;
  localparam int DATA_W_DFLT = 32;
  localparam int N_REG_DFLT  = 3;

  // Region i occupies bits [ADDR_W*i +: ADDR_W]
  localparam logic [N_REG_DFLT*ADDR_W_DFLT-1:0] BASE_DFLT =
    {32'h4000_3000, 32'h4000_1000, 32'h4000_0000};
  localparam logic [N_REG_DFLT*ADDR_W_DFLT-1:0] LIMIT_DFLT =
    {32'h4000_3FFF, 32'h4000_1FFF, 32'h4000_0FFF};

  typedef struct packed {
    logic ready;
    logic err;
  } rsp_flags_t;
endpackage

// File: rtl/region_match.sv
module region_match #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE  = '0,
  parameter logic [ADDR_W-1:0] LIMIT = '1
) (
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              sel
);
  always_comb begin
    hit = (addr >= BASE) && (addr <= LIMIT);
    sel = bus_sel & hit;
  end
endmodule

// File: rtl/err_responder.sv
module err_responder
  import apb_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dflt_sel,
  input  logic       enable,
  output rsp_flags_t flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (dflt_sel && enable) begin
      flags <= '{ready: 1'b1, err: 1'b1};
    end else begin
      flags <= '0;
    end
  end

  AST_ONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (dflt_sel && enable && !flags.ready) |=> flags.ready) else $error("one wait"); // R5
  AST_ERR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags.ready) |-> $past(dflt_sel && enable)) else $error("paired"); // R4
endmodule

// File: rtl/resp_mux.sv
module resp_mux
  import apb_dec_pkg::*;
#(
  parameter int N_REG  = 3,
  parameter int DATA_W = 32
) (
  input  logic                    dflt_sel,
  input  rsp_flags_t              dflt_flags,
  input  logic [N_REG-1:0]        tgt_sel,
  input  logic [N_REG-1:0]        tgt_ready,
  input  logic [N_REG-1:0]        tgt_err,
  input  logic [N_REG*DATA_W-1:0] tgt_rdata,
  output logic                    ready,
  output logic                    err,
  output logic [DATA_W-1:0]       rdata
);
  always_comb begin
    ready = 1'b0;
    err   = 1'b0;
    rdata = '0;
    // descending walk: lowest-numbered selected region wins
    for (int i = N_REG - 1; i >= 0; i--) begin
      if (tgt_sel[i]) begin
        ready = tgt_ready[i];
        err   = tgt_err[i];
        rdata = tgt_rdata[DATA_W*i +: DATA_W];
      end
    end
    if (dflt_sel) begin
      ready = dflt_flags.ready;
      err   = dflt_flags.err;
      rdata = '0;
    end
  end
endmodule

// File: rtl/apb_hole_decoder.sv
module apb_hole_decoder
  import apb_dec_pkg::*;
#(
  parameter int ADDR_W   = ADDR_W_DFLT,
  parameter int DATA_W   = DATA_W_DFLT,
  parameter int N_REG    = N_REG_DFLT,
  parameter logic [N_REG*ADDR_W-1:0] REG_BASE  = BASE_DFLT,
  parameter logic [N_REG*ADDR_W-1:0] REG_LIMIT = LIMIT_DFLT,
  parameter int MAX_WAIT = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mgr_sel,
  input  logic                    mgr_enable,
  input  logic [ADDR_W-1:0]       mgr_addr,
  output logic                    mgr_ready,
  output logic                    mgr_err,
  output logic [DATA_W-1:0]       mgr_rdata,
  output logic [N_REG-1:0]        tgt_sel,
  input  logic [N_REG-1:0]        tgt_ready,
  input  logic [N_REG-1:0]        tgt_err,
  input  logic [N_REG*DATA_W-1:0] tgt_rdata
);
  localparam int CNT_W = $clog2(MAX_WAIT + 1) + 1;

  logic [N_REG-1:0] hit_vec;
  logic             dflt_sel;
  rsp_flags_t       dflt_flags;

  for (genvar g = 0; g < N_REG; g++) begin : g_region
    region_match #(
      .ADDR_W(ADDR_W),
      .BASE  (REG_BASE [ADDR_W*g +: ADDR_W]),
      .LIMIT (REG_LIMIT[ADDR_W*g +: ADDR_W])
    ) u_match (
      .bus_sel(mgr_sel),
      .addr   (mgr_addr),
      .hit    (hit_vec[g]),
      .sel    (tgt_sel[g])
    );
  end

  assign dflt_sel = mgr_sel & ~(|hit_vec);

  err_responder u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .dflt_sel(dflt_sel),
    .enable  (mgr_enable),
    .flags   (dflt_flags)
  );

  resp_mux #(.N_REG(N_REG), .DATA_W(DATA_W)) u_mux (
    .dflt_sel  (dflt_sel),
    .dflt_flags(dflt_flags),
    .tgt_sel   (tgt_sel),
    .tgt_ready (tgt_ready),
    .tgt_err   (tgt_err),
    .tgt_rdata (tgt_rdata),
    .ready     (mgr_ready),
    .err       (mgr_err),
    .rdata     (mgr_rdata)
  );

  // Stall window counter for the bounded-completion check
  logic [CNT_W-1:0] wait_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
    end else if (mgr_sel && mgr_enable && !mgr_ready) begin
      if (wait_cnt < CNT_W'(MAX_WAIT)) wait_cnt <= wait_cnt + 1'b1;
    end else begin
      wait_cnt <= '0;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mgr_sel && mgr_enable) |-> $onehot({tgt_sel, dflt_sel})) else $error("onehot"); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mgr_sel |-> (tgt_sel == '0 && !mgr_ready && !mgr_err)) else $error("idle"); // R2
  AST_NOHIT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (dflt_sel && mgr_enable && mgr_ready) |-> (mgr_err && mgr_rdata == '0)) else $error("nohit"); // R4
  AST_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt < CNT_W'(MAX_WAIT)) else $error("stall"); // R9
endmodule

// File: tb/tb_apb_hole_decoder.sv
`timescale 1ns/1ps
module tb_apb_hole_decoder;
  localparam int N = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mgr_sel = 1'b0, mgr_enable = 1'b0;
  logic [31:0] mgr_addr = '0;
  logic mgr_ready, mgr_err;
  logic [31:0] mgr_rdata;
  logic [N-1:0] tgt_sel;
  logic [N-1:0] tgt_ready = '0, tgt_err = '0;
  logic [N*32-1:0] tgt_rdata;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  apb_hole_decoder dut (
    .clk(clk), .rst_n(rst_n), .mgr_sel(mgr_sel), .mgr_enable(mgr_enable),
    .mgr_addr(mgr_addr), .mgr_ready(mgr_ready), .mgr_err(mgr_err),
    .mgr_rdata(mgr_rdata), .tgt_sel(tgt_sel), .tgt_ready(tgt_ready),
    .tgt_err(tgt_err), .tgt_rdata(tgt_rdata)
  );

  function automatic logic [31:0] pdata(int i, logic [31:0] a);
    return 32'hC0DE_0000 | (i << 12) | {20'h0, a[11:0]};
  endfunction

  always_comb
    for (int i = 0; i < N; i++) tgt_rdata[32*i +: 32] = pdata(i, mgr_addr);

  function automatic int region_of(logic [31:0] a);
    if (a >= 32'h4000_0000 && a <= 32'h4000_0FFF) return 0;
    if (a >= 32'h4000_1000 && a <= 32'h4000_1FFF) return 1;
    if (a >= 32'h4000_3000 && a <= 32'h4000_3FFF) return 2;
    return -1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h addr=%h", req, act, exp, mgr_addr);
    end
  endtask

  task automatic access(logic [31:0] a, int waits, logic ev);
    int r = region_of(a);
    logic [N-1:0] exp_sel = (r < 0) ? '0 : N'(1 << r);
    bit done = 0;
    @(negedge clk);
    mgr_sel = 1'b1; mgr_enable = 1'b0; mgr_addr = a;
    tgt_ready = '0; tgt_err = '0;
    #1 chk("R1", 32'(tgt_sel), 32'(exp_sel));
    @(negedge clk);
    mgr_enable = 1'b1;
    for (int k = 0; k < 8 && !done; k++) begin
      if (k > 0) @(negedge clk);
      if (r >= 0) begin
        tgt_ready = (k >= waits) ? '1 : '0;
        tgt_err   = ev ? '1 : '0;
        #1;
        chk("R7", 32'(mgr_ready), 32'(k >= waits));
        if (k >= waits) begin
          chk("R7", 32'(mgr_err), 32'(ev));
          chk("R7", mgr_rdata, pdata(r, a));
          done = 1;
        end
      end else begin
        tgt_ready = '1; tgt_err = '1; // must not leak into a no-hit
        #1;
        chk("R5", 32'(mgr_ready), 32'(k >= 1));
        if (k >= 1) begin
          chk("R4", 32'(mgr_err), 32'h1);
          chk("R8", mgr_rdata, 32'h0);
          done = 1;
        end
      end
    end
    if (!done) chk("R9", 32'h0, 32'h1);
    @(negedge clk);
    mgr_sel = 1'b0; mgr_enable = 1'b0; tgt_ready = '1; tgt_err = '1;
    #1;
    chk("R2", 32'(tgt_sel), 32'h0);
    chk("R2", 32'(mgr_ready), 32'h0);
    chk("R2", 32'(mgr_err), 32'h0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] addrs[14] = '{
      32'h4000_0000, 32'h4000_0FFF, 32'h4000_1000, 32'h4000_1FFF,
      32'h4000_2000, 32'h4000_2400, 32'h4000_2FFF, 32'h4000_3000,
      32'h4000_3FFF, 32'h4000_4000, 32'h3FFF_FFFF, 32'h0000_0000,
      32'hFFFF_FFFF, 32'h4000_0800};
    mgr_sel = 1'b1; mgr_enable = 1'b1; mgr_addr = 32'h4000_2400;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6", 32'(mgr_ready), 32'h0);
    chk("R6", 32'(mgr_err), 32'h0);
    mgr_sel = 1'b0; mgr_enable = 1'b0;
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++)
      foreach (addrs[i]) access(addrs[i], p % 3, p[0]);
    // back-to-back alternation of hit and no-hit
    for (int i = 0; i < 6; i++) begin
      access(32'h4000_1FFF, 0, 1'b1);
      access(32'h4000_2000, 0, 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule